// File: doc/BRIEF.md
# Banked-Register AND Execute Unit

This unit carries out one instruction: the bitwise AND of the working register with one byte of banked data memory. Each instruction occupies one instruction cycle of four clocks. The phases run in a fixed order: decode, read, process, write. The unit samples the 16-bit instruction word, the working register, the bank select value and the status bits at the end of the decode phase. It then reads the addressed byte through a synchronous memory port and forms the result. In the write phase it sends the result either back to memory or to the working-register output.

An instruction bit picks the data address. With it clear, the byte address selects a fixed access window: low addresses fall in bank 0 and high addresses in the top bank. With it set, the bank select value supplies the upper address bits. Only the negative and zero status bits change. An instruction word with any other opcode raises an illegal flag, makes no memory access and changes no state.

Top module: `bank_and_unit`

## Requirements
- R1: The instruction is recognised when bits [15:10] equal 6'b000101. Bit 9 selects the destination (1 = memory), bit 8 selects banked addressing (1 = banked), and bits [7:0] give the byte address.
- R2: The result is the sampled working register ANDed with the memory byte. When bit 9 is 0, the result appears on `w_out` after the instruction cycle and memory is left unchanged.
- R3: When bit 9 is 1, the result is written to the addressed memory byte and `w_out` takes the sampled working register unchanged.
- R4: With bit 8 clear, a byte address below 0x80 maps to data address 0x000 plus the byte address. A byte address of 0x80 or above maps to 0xF00 plus the byte address.
- R5: With bit 8 set, the 12-bit data address is the 4-bit bank select value followed by the byte address.
- R6: `status_out` equals the sampled status with bit 4 set to bit 7 of the result and bit 2 set when the result is zero. Bits 3, 1 and 0 keep their sampled values.
- R7: `phase` steps 0 (decode), 1 (read), 2 (process), 3 (write) and back to 0. One instruction completes every four clocks, and results update on the clock that ends phase 3.
- R8: `mem_rd` is high only during phase 1 of a recognised instruction. `mem_wr` is high only during phase 3 of a recognised instruction with bit 9 set, and it carries the same address as the read.
- R9: An unrecognised word sets `illegal` for the next instruction cycle and issues no memory read or write. `w_out` and `status_out` then equal the sampled working register and status.
- R10: Synchronous active-low reset puts `phase` at 0 and clears `w_out`, `status_out`, `illegal`, `mem_rd` and `mem_wr`.
- R11: The inputs are sampled only at the clock that ends phase 0. Changes during phases 1 to 3 have no effect on that instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr | input | 16 | Instruction word, sampled at end of phase 0 |
| w_in | input | 8 | Working register value |
| bank_sel | input | 4 | Bank select value for banked addressing |
| status_in | input | 5 | Status bits before the instruction |
| mem_rdata | input | 8 | Read data, valid the clock after `mem_rd` |
| mem_addr | output | 12 | Data memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data (the result) |
| w_out | output | 8 | Working register after the instruction |
| status_out | output | 5 | Status bits after the instruction |
| illegal | output | 1 | Last instruction word was not recognised |
| phase | output | 2 | Current phase within the instruction cycle |

## Verification
After the sampling clock, the read strobe and its address are due in the next cycle, phase 1. The write strobe and its data come two cycles after that, in phase 3. `w_out`, `status_out`, `illegal` and the memory contents are due four cycles after sampling, once phase 0 returns. The bench steps an instruction one clock at a time and compares every output at the falling edge against the value its model expects for that phase. It checks the memory byte after the write clock.

// File: rtl/bank_and_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the banked-register AND unit.
// Assumes a 16-bit instruction word whose top six bits carry the opcode.
package bank_and_pkg;
    localparam logic [5:0] AND_OPCODE = 6'b000101;

    typedef enum logic [1:0] {
        PH_DECODE  = 2'd0,
        PH_READ    = 2'd1,
        PH_PROCESS = 2'd2,
        PH_WRITE   = 2'd3
    } phase_t;
endpackage

// File: rtl/bank_and_phase_seq.sv
`timescale 1ns/1ps
// Four-phase sequencer: decode, read, process, write, repeating.
// Assumes one instruction per four clocks with no stall input.
module bank_and_phase_seq
    import bank_and_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_t phase
);
    // Advance one phase per clock, wrapping after the write phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_DECODE;
        end else begin
            case (phase)
                PH_DECODE:  phase <= PH_READ;
                PH_READ:    phase <= PH_PROCESS;
                PH_PROCESS: phase <= PH_WRITE;
                default:    phase <= PH_DECODE;
            endcase
        end
    end
endmodule

// File: rtl/bank_and_decode.sv
`timescale 1ns/1ps
// Field decode and data-address formation for a captured instruction word.
// Assumes the opcode sits in the top six bits, followed by destination and bank bits.
module bank_and_decode
    import bank_and_pkg::*;
#(
    parameter int INSTR_W = 16,
    parameter int BANK_W  = 4,
    parameter int F_W     = 8,
    localparam int ADDR_W = BANK_W + F_W
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic [BANK_W-1:0]  bank_sel,
    output logic               match,
    output logic               to_mem,
    output logic [ADDR_W-1:0]  addr
);
    localparam int D_POS = INSTR_W - 7;
    localparam int A_POS = INSTR_W - 8;

    logic [F_W-1:0] f_sel;
    logic           banked;

    // Split the word into opcode, destination, bank mode and byte address.
    always_comb begin
        match  = (instr[INSTR_W-1 -: 6] == AND_OPCODE);
        to_mem = instr[D_POS];
        banked = instr[A_POS];
        f_sel  = instr[F_W-1:0];
    end

    // Form the data address: banked, or access window split by the byte MSB.
    always_comb begin
        if (banked)
            addr = {bank_sel, f_sel};
        else if (f_sel[F_W-1])
            addr = {{BANK_W{1'b1}}, f_sel};
        else
            addr = {{BANK_W{1'b0}}, f_sel};
    end
endmodule

// File: rtl/bank_and_alu.sv
`timescale 1ns/1ps
// AND datapath with a result register loaded in the process phase.
// Assumes the memory byte is valid during the cycle when load is high.
module bank_and_alu #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] w_val,
    input  logic [DATA_W-1:0] m_val,
    output logic [DATA_W-1:0] res,
    output logic              neg,
    output logic              zero
);
    // Hold the AND result for the write phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            res <= '0;
        else if (load)
            res <= w_val & m_val;
    end

    // Derive the sign and zero indications from the held result.
    always_comb begin
        neg  = res[DATA_W-1];
        zero = (res == '0);
    end
endmodule

// File: rtl/bank_and_unit.sv
`timescale 1ns/1ps
// Top of the banked-register AND unit: samples inputs in decode, reads memory,
// forms the result, then commits it to memory or the working register.
// Assumes a synchronous memory returning read data one clock after mem_rd.
module bank_and_unit
    import bank_and_pkg::*;
#(
    parameter int INSTR_W = 16,
    parameter int DATA_W  = 8,
    parameter int BANK_W  = 4,
    parameter int F_W     = 8,
    parameter int STAT_W  = 5,
    parameter int N_BIT   = 4,
    parameter int Z_BIT   = 2,
    localparam int ADDR_W = BANK_W + F_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr,
    input  logic [DATA_W-1:0]  w_in,
    input  logic [BANK_W-1:0]  bank_sel,
    input  logic [STAT_W-1:0]  status_in,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic [DATA_W-1:0]  w_out,
    output logic [STAT_W-1:0]  status_out,
    output logic               illegal,
    output logic [1:0]         phase
);
    phase_t              ph;
    logic [INSTR_W-1:0]  instr_q;
    logic [DATA_W-1:0]   w_q;
    logic [BANK_W-1:0]   bank_q;
    logic [STAT_W-1:0]   stat_q;
    logic                match;
    logic                to_mem;
    logic [ADDR_W-1:0]   addr;
    logic [DATA_W-1:0]   res;
    logic                neg;
    logic                zero;
    logic [STAT_W-1:0]   stat_new;

    bank_and_phase_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (ph)
    );

    bank_and_decode #(
        .INSTR_W (INSTR_W),
        .BANK_W  (BANK_W),
        .F_W     (F_W)
    ) u_dec (
        .instr    (instr_q),
        .bank_sel (bank_q),
        .match    (match),
        .to_mem   (to_mem),
        .addr     (addr)
    );

    bank_and_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .clk   (clk),
        .rst_n (rst_n),
        .load  ((ph == PH_PROCESS) && match),
        .w_val (w_q),
        .m_val (mem_rdata),
        .res   (res),
        .neg   (neg),
        .zero  (zero)
    );

    // Sample the instruction and operands at the end of the decode phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            instr_q <= '0;
            w_q     <= '0;
            bank_q  <= '0;
            stat_q  <= '0;
        end else if (ph == PH_DECODE) begin
            instr_q <= instr;
            w_q     <= w_in;
            bank_q  <= bank_sel;
            stat_q  <= status_in;
        end
    end

    // Merge the new sign and zero bits into the sampled status.
    always_comb begin
        stat_new        = stat_q;
        stat_new[N_BIT] = neg;
        stat_new[Z_BIT] = zero;
    end

    // Drive the memory port from the phase and decoded fields.
    always_comb begin
        mem_addr  = addr;
        mem_wdata = res;
        mem_rd    = (ph == PH_READ) && match;
        mem_wr    = (ph == PH_WRITE) && match && to_mem;
        phase     = ph;
    end

    // Commit working register, status and illegal flag at the end of the write phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_out      <= '0;
            status_out <= '0;
            illegal    <= 1'b0;
        end else if (ph == PH_WRITE) begin
            w_out      <= (match && !to_mem) ? res : w_q;
            status_out <= match ? stat_new : stat_q;
            illegal    <= !match;
        end
    end

    // A write must follow a read of the same address two clocks earlier.
    p_wr_after_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> ($past(mem_rd, 2) && ($past(mem_addr, 2) == mem_addr)));

    // An unrecognised word leaves the memory port idle for its whole cycle.
    p_illegal_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_DECODE && illegal) |-> (!$past(mem_wr) && !$past(mem_rd, 3)));

    // A memory-destination instruction hands the sampled working register through.
    p_w_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_DECODE && $past(mem_wr)) |-> (w_out == $past(w_q)));

    // Committed flags agree with the result still held for the write.
    p_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_DECODE && $past(ph == PH_WRITE) && !illegal) |->
        ((status_out[Z_BIT] == (mem_wdata == '0)) &&
         (status_out[N_BIT] == mem_wdata[DATA_W-1])));
endmodule

// File: tb/sim_bank_and_unit.sv
`timescale 1ns/1ps
module sim_bank_and_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr = 16'h0000;
    logic [7:0]  w_in = 8'h00;
    logic [3:0]  bank_sel = 4'h0;
    logic [4:0]  status_in = 5'h00;
    logic [7:0]  mem_rdata = 8'h00;
    logic [11:0] mem_addr;
    logic        mem_rd;
    logic        mem_wr;
    logic [7:0]  mem_wdata;
    logic [7:0]  w_out;
    logic [4:0]  status_out;
    logic        illegal;
    logic [1:0]  phase;

    logic [7:0] mem [0:4095];
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    bank_and_unit u0 (
        .clk(clk), .rst_n(rst_n), .instr(instr), .w_in(w_in),
        .bank_sel(bank_sel), .status_in(status_in), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .w_out(w_out), .status_out(status_out),
        .illegal(illegal), .phase(phase)
    );

    // Synchronous data memory model.
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr];
        if (mem_wr) mem[mem_addr] <= mem_wdata;
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Run one instruction, checking outputs at every falling edge.
    task automatic run(input logic [15:0] iw, input logic [7:0] w,
                       input logic [3:0] bs, input logic [4:0] st);
        bit legal;
        bit dst;
        int f;
        int ea;
        int m;
        int r;
        int exp_st;
        legal = (iw[15:10] == 6'b000101);
        dst   = iw[9];
        f     = iw[7:0];
        if (iw[8])        ea = bs * 256 + f;
        else if (f >= 128) ea = 'hF00 + f;
        else              ea = f;
        m = mem[ea];
        r = w & m;
        exp_st = st;
        if (legal) begin
            exp_st[4] = r[7];
            exp_st[2] = (r == 0);
        end
        chk("R7 phase decode", phase, 0);
        instr = iw; w_in = w; bank_sel = bs; status_in = st;
        @(negedge clk);
        // R11: disturb inputs after sampling
        instr = 16'h17FF; w_in = ~w; bank_sel = ~bs; status_in = ~st;
        chk("R7 phase read", phase, 1);
        chk("R8 read strobe", mem_rd, legal);
        chk("R9 no write in read", mem_wr, 0);
        if (legal) chk(iw[8] ? "R5 banked address" : "R4 access address", mem_addr, ea);
        @(negedge clk);
        chk("R7 phase process", phase, 2);
        chk("R8 idle in process", {mem_rd, mem_wr}, 0);
        @(negedge clk);
        chk("R7 phase write", phase, 3);
        chk("R8 write strobe", mem_wr, legal && dst);
        chk("R8 no read in write", mem_rd, 0);
        if (legal && dst) begin
            chk("R8 write address", mem_addr, ea);
            chk("R3 write data", mem_wdata, r);
        end
        @(negedge clk);
        chk("R7 phase wrap", phase, 0);
        chk("R9 illegal flag", illegal, !legal);
        chk("R2 R3 R11 w_out", w_out, (legal && !dst) ? r : w);
        chk("R6 R9 status", status_out, exp_st);
        chk("R2 R3 memory byte", mem[ea], (legal && dst) ? r : m);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'((i * 37) ^ (i >> 4));
        instr = 16'hFFFF; w_in = 8'hAA; status_in = 5'h1F;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 phase", phase, 0);
        chk("R10 strobes", {mem_rd, mem_wr}, 0);
        chk("R10 w_out", w_out, 0);
        chk("R10 status", status_out, 0);
        chk("R10 illegal", illegal, 0);
        rst_n = 1'b1;
        // R2 example: register byte AND, result to working register
        mem['h020] = 8'hC2;
        run({6'b000101, 1'b0, 1'b0, 8'h20}, 8'h17, 4'h0, 5'h00);
        // R3: same, result to memory
        run({6'b000101, 1'b1, 1'b0, 8'h20}, 8'h17, 4'h0, 5'h00);
        // R4: upper access window
        run({6'b000101, 1'b1, 1'b0, 8'h85}, 8'hF0, 4'h7, 5'h1F);
        run({6'b000101, 1'b0, 1'b0, 8'h7F}, 8'h3C, 4'h7, 5'h01);
        // R5: banked addressing
        run({6'b000101, 1'b1, 1'b1, 8'h85}, 8'hCC, 4'h3, 5'h0B);
        run({6'b000101, 1'b0, 1'b1, 8'h10}, 8'h5A, 4'hE, 5'h00);
        // R6: zero result keeps other status bits
        mem['h044] = 8'hF0;
        run({6'b000101, 1'b0, 1'b0, 8'h44}, 8'h0F, 4'h0, 5'b01011);
        // R6: negative result
        mem['h045] = 8'h80;
        run({6'b000101, 1'b0, 1'b0, 8'h45}, 8'hFF, 4'h0, 5'b00101);
        // R1 R9: neighbouring and empty opcodes
        run(16'h1B20, 8'h99, 4'h2, 5'h15);
        run(16'h0000, 8'h42, 4'h0, 5'h0A);
        run(16'h1320, 8'h11, 4'h1, 5'h03);
        // R1: varied legal words
        for (int k = 0; k < 24; k++) begin
            run({6'b000101, 1'(k), 1'(k >> 1), 8'(k * 53 + 7)},
                8'(k * 29 + 3), 4'(k * 5), 5'(k * 7));
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule